// File: doc/BRIEF.md
# E3 Frame-Master Transmit Payload Interface

This block sits on the transmit side of an E3 framer that owns the frame timing. A free-running bit counter, stepped by the 34.368 MHz transmit clock, divides the outbound stream into 1536-bit frames. The same clock also drives the terminal equipment. The block tells the terminal where each frame ends and which slots are overhead. It samples the terminal's serial payload on every rising edge and replaces the overhead slots with bits it generates itself. The result is one registered serial E3 bit stream with a valid strobe and a first-bit marker.

The terminal acts as the slave. It watches the frame-end pulse and places the first payload-frame bit on the serial input in the very next cycle. Whenever the overhead warning is high, it holds back payload for the following slot. No external frame-sync signal exists: frame timing comes from the local counter alone.

Top module: `e3fm_tx_payload_if`

## Requirements
- R1: `frameOut` is high for exactly one clock per frame, in the cycle that handles bit position 1536. Consecutive pulses are exactly 1536 cycles apart, whatever the data inputs do.
- R2: While `rst` is high, `frameOut`, `ohInd`, `txValid` and `txFirst` are all low.
- R3: In the first clock cycle after `rst` falls, `frameOut` is high. The `serIn` value sampled in the following cycle is bit position 1 of the first frame.
- R4: `ohInd` is high in the bit-1536 cycle and in the cycles for bit positions 1 to 11, and low in every other cycle. It therefore precedes each of the 12 overhead positions by exactly one clock.
- R5: For payload positions 13 to 1536, `txData` equals the `serIn` value sampled one clock earlier.
- R6: For overhead positions 1 to 12, `serIn` is ignored. Positions 1 to 10 carry the alignment pattern 1,1,1,1,0,1,0,0,0,0 (position 1 first). Position 11 carries `alarmBit` and position 12 carries `nationalBit`, each as sampled in that slot's cycle. The bit appears on `txData` one clock later.
- R7: `txFirst` is high for one clock, in the cycle in which bit position 1 of a frame is on `txData`, and low otherwise.
- R8: `txValid` is low after reset until bit position 1 of the first frame reaches `txData`. From then on it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 34.368 MHz transmit clock, shared with the terminal |
| rst | input | 1 | Synchronous active-high reset |
| serIn | input | 1 | Serial payload from the terminal, sampled on the rising edge |
| alarmBit | input | 1 | Value sent in overhead position 11 |
| nationalBit | input | 1 | Value sent in overhead position 12 |
| frameOut | output | 1 | High during the last bit position of each frame |
| ohInd | output | 1 | High one clock before each overhead position |
| txData | output | 1 | Merged serial E3 bit, registered |
| txValid | output | 1 | High once the first frame has started leaving the block |
| txFirst | output | 1 | Marks bit position 1 on txData |

## Verification
The hardest case to reach is a terminal that ignores the overhead warning and keeps driving payload into overhead slots. Random data alone would match the generated overhead bit about half the time, so a faulty merge could go unnoticed. To close that gap, the stimulus drives `serIn` to the inverse of the expected overhead bit in every overhead slot of alternate frames. A second reset in the middle of a frame then shows that frame timing restarts from the reset alone.

// File: rtl/e3fm_pkg.sv
package e3fm_pkg;
  typedef struct packed {
    logic lastBit;   // final bit position of the frame
    logic ohAhead;   // next slot is overhead
    logic ohSlot;    // current slot is overhead
    logic firstBit;  // current slot is bit position 1
  } e3fmStrobes_t;
endpackage

// File: rtl/e3fm_ctrl.sv
module e3fm_ctrl
  import e3fm_pkg::*;
#(
  parameter int FRAME_BITS = 1536,
  parameter int OH_BITS    = 12,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  output e3fmStrobes_t     strb,
  output logic [IDX_W-1:0] ohIdx
);
  localparam int POS_W = $clog2(FRAME_BITS);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic [POS_W-1:0] bitPos;

  always_ff @(posedge clk) begin
    if (rst)                   bitPos <= LAST_POS;
    else if (bitPos == LAST_POS) bitPos <= '0;
    else                       bitPos <= bitPos + 1'b1;
  end

  always_comb begin
    strb.lastBit  = !rst && (bitPos == LAST_POS);
    strb.ohAhead  = !rst && ((bitPos == LAST_POS) || (bitPos < POS_W'(OH_BITS - 1)));
    strb.ohSlot   = !rst && (bitPos < POS_W'(OH_BITS));
    strb.firstBit = !rst && (bitPos == '0);
    ohIdx         = strb.ohSlot ? bitPos[IDX_W-1:0] : '0;
  end

  // Assertion support: cycles since the last frame pulse
  logic [POS_W:0] gapCnt;
  logic           seenLast;
  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt   <= '0;
      seenLast <= 1'b0;
    end else if (strb.lastBit) begin
      gapCnt   <= '0;
      seenLast <= 1'b1;
    end else begin
      gapCnt   <= gapCnt + 1'b1;
    end
  end

  p_frame_period_r1: assert property (@(posedge clk) disable iff (rst)
    (strb.lastBit && seenLast) |-> (gapCnt == (POS_W+1)'(FRAME_BITS - 1)));
  p_frame_single_r1: assert property (@(posedge clk) disable iff (rst)
    strb.lastBit |=> !strb.lastBit);
  p_wrap_first_r3: assert property (@(posedge clk) disable iff (rst)
    strb.lastBit |=> strb.firstBit);
  p_oh_lead_r4: assert property (@(posedge clk) disable iff (rst)
    strb.ohAhead |=> strb.ohSlot);
  p_oh_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !strb.ohAhead |=> !strb.ohSlot);
endmodule

// File: rtl/e3fm_dpath.sv
module e3fm_dpath
  import e3fm_pkg::*;
#(
  parameter int                    ALIGN_LEN     = 10,
  parameter logic [ALIGN_LEN-1:0]  ALIGN_PATTERN = 10'b1111010000,
  parameter int                    IDX_W         = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  e3fmStrobes_t     strb,
  input  logic [IDX_W-1:0] ohIdx,
  input  logic             serIn,
  input  logic             alarmBit,
  input  logic             nationalBit,
  output logic             txData,
  output logic             txValid,
  output logic             txFirst
);
  logic ohBit;
  logic mergedBit;

  always_comb begin
    ohBit = nationalBit;
    if (int'(ohIdx) < ALIGN_LEN)       ohBit = ALIGN_PATTERN[ALIGN_LEN - 1 - int'(ohIdx)];
    else if (int'(ohIdx) == ALIGN_LEN) ohBit = alarmBit;
    mergedBit = strb.ohSlot ? ohBit : serIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txData  <= 1'b0;
      txValid <= 1'b0;
      txFirst <= 1'b0;
    end else begin
      txData  <= mergedBit;
      txFirst <= strb.firstBit;
      txValid <= txValid | strb.firstBit;
    end
  end

  p_payload_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(strb.ohSlot)) |-> (txData == $past(serIn)));
  p_first_align_r7: assert property (@(posedge clk) disable iff (rst)
    txFirst |-> (txData == ALIGN_PATTERN[ALIGN_LEN-1]));
  p_first_valid_r8: assert property (@(posedge clk) disable iff (rst)
    txFirst |-> txValid);
  p_valid_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    $past(txValid) |-> txValid);
endmodule

// File: rtl/e3fm_tx_payload_if.sv
module e3fm_tx_payload_if
  import e3fm_pkg::*;
#(
  parameter int                   FRAME_BITS    = 1536,
  parameter int                   ALIGN_LEN     = 10,
  parameter logic [ALIGN_LEN-1:0] ALIGN_PATTERN = 10'b1111010000
) (
  input  logic clk,
  input  logic rst,
  input  logic serIn,
  input  logic alarmBit,
  input  logic nationalBit,
  output logic frameOut,
  output logic ohInd,
  output logic txData,
  output logic txValid,
  output logic txFirst
);
  localparam int OH_BITS = ALIGN_LEN + 2;
  localparam int IDX_W   = $clog2(OH_BITS);

  e3fmStrobes_t     strb;
  logic [IDX_W-1:0] ohIdx;

  e3fm_ctrl #(.FRAME_BITS(FRAME_BITS), .OH_BITS(OH_BITS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .strb(strb), .ohIdx(ohIdx)
  );

  e3fm_dpath #(.ALIGN_LEN(ALIGN_LEN), .ALIGN_PATTERN(ALIGN_PATTERN), .IDX_W(IDX_W)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .ohIdx(ohIdx),
    .serIn(serIn), .alarmBit(alarmBit), .nationalBit(nationalBit),
    .txData(txData), .txValid(txValid), .txFirst(txFirst)
  );

  assign frameOut = strb.lastBit;
  assign ohInd    = strb.ohAhead;

  p_reset_quiet_r2: assert property (@(posedge clk)
    rst |-> (!frameOut && !ohInd));
endmodule

// File: tb/e3fm_tx_payload_if_test.sv
module e3fm_tx_payload_if_test;
  localparam int PERIOD = 10;
  localparam int FRAME  = 1536;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serIn = 1'b0, alarmBit = 1'b0, nationalBit = 1'b0;
  logic frameOut, ohInd, txData, txValid, txFirst;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  e3fm_tx_payload_if uut (
    .clk(clk), .rst(rst), .serIn(serIn), .alarmBit(alarmBit), .nationalBit(nationalBit),
    .frameOut(frameOut), .ohInd(ohInd), .txData(txData), .txValid(txValid), .txFirst(txFirst)
  );

  // Overhead value for position p (1-based), independent of the design
  function automatic logic ohValue(int p, logic al, logic na);
    logic [9:0] pat = 10'b1111010000;
    if (p <= 10) return pat[10 - p];
    if (p == 11) return al;
    return na;
  endfunction

  function automatic logic expBit(int p, logic s, logic al, logic na);
    return (p <= 12) ? ohValue(p, al, na) : s;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Runs nCyc cycles after reset release; p is 1-based bit position
  task automatic runFrames(int nCyc, int seed);
    int  p = FRAME;
    int  prevP = 0;
    bit  havePrev = 0;
    bit  seen = 0;
    logic expD = 1'b0;
    int  frameNo = 0;
    void'($urandom(seed));
    for (int c = 0; c < nCyc; c++) begin
      #1;
      if (c == 0) check("R3 frame pulse right after reset", frameOut, 1'b1);
      check("R1 frameOut", frameOut, p == FRAME);
      check("R4 ohInd", ohInd, (p == FRAME) || (p <= 11));
      if (havePrev) begin
        check(prevP <= 12 ? "R6 overhead bit" : "R5 payload bit", txData, expD);
        check("R7 txFirst", txFirst, prevP == 1);
      end else begin
        check("R7 txFirst idle", txFirst, 1'b0);
      end
      check("R8 txValid", txValid, seen);
      if (p == 1) frameNo++;
      serIn       = 1'($urandom);
      alarmBit    = 1'($urandom);
      nationalBit = 1'($urandom);
      // Directed: terminal drives the opposite of overhead in alternate frames
      if (p <= 12 && frameNo[0]) serIn = ~ohValue(p, alarmBit, nationalBit);
      expD     = expBit(p, serIn, alarmBit, nationalBit);
      seen     = seen | (havePrev && prevP == 1);
      havePrev = (p != FRAME) || havePrev;
      if (p == FRAME && !havePrev) havePrev = 1;
      prevP = p;
      p = (p == FRAME) ? 1 : p + 1;
      @(posedge clk);
      @(negedge clk);
      if (prevP == 1) seen = 1;
    end
  endtask

  task automatic doReset(int cyc);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < cyc; i++) begin
      @(posedge clk);
      @(negedge clk);
      #1;
      check("R2 frameOut in reset", frameOut, 1'b0);
      check("R2 ohInd in reset", ohInd, 1'b0);
      check("R2 txValid in reset", txValid, 1'b0);
      check("R2 txFirst in reset", txFirst, 1'b0);
    end
    rst = 1'b0;
  endtask

  initial begin
    doReset(3);
    runFrames(3 * FRAME + 40, 7);
    // Reset in mid-frame: timing must restart from the reset
    doReset(2);
    runFrames(2 * FRAME + 20, 11);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule